// File: doc/BRIEF.md
# Three-Level Trie Route Lookup Pipeline

This block resolves the longest matching route for a 32-bit destination address by walking a three-level trie held in one external memory. Each level of the walk is handled by its own pipeline stage, and decoupling queues sit between the stages. A stage reads memory only when its lookup is still unresolved. A lookup that already reached a leaf moves through the later stages without touching memory. All read requests share one memory read port through a stage arbiter. The arbiter records which stage issued each read so that every returning word reaches the right stage. The memory may take any number of cycles to answer, as long as it answers in issue order.

Software or an upstream packet engine offers addresses on a valid/ready request port. Results leave on a valid/ready response port in the same order the addresses were accepted, together with the address that produced them. Table contents are loaded by other means and are treated here as read-only.

Top module: `lpm_linear_pipe`

## Requirements
- R1: While reset is asserted and in the first cycle after it, resp_valid and mem_req_valid are low.
- R2: Every lookup issues a first read at address {8'h00, ip[31:24]}, zero-extended to the address width. If that word has bit 15 set (leaf), the result is bits 14:0 of the word and no further read is made.
- R3: A word with bit 15 clear is a node. Its bits 14:0 are a base, and the next read address is base plus the next address octet: ip[23:16] for the second read and ip[15:8] for the third. A leaf at the second or third read supplies the result from bits 14:0.
- R4: A lookup that resolves at read L (1, 2 or 3) makes exactly L memory reads. Later stages pass it on without a read.
- R5: The word returned by the third read is taken as the result (bits 14:0) whether or not bit 15 is set.
- R6: Results leave in the order the lookups were accepted, each paired with its own address on resp_ip.
- R7: Results are correct for any read latency of one cycle or more and for any pattern of mem_req_ready, given in-order read data.
- R8: At most one read is issued per cycle. When several stages want a read, the deepest stage wins. A new lookup is accepted only in the cycle its first read is issued, so req_valid && req_ready implies that mem_req_addr is that lookup's first address.
- R9: While resp_valid is high and resp_ready is low, the response stays unchanged. Each of the four lookup queues holds 4 lookups. A full queue stalls the stage feeding it, so at most 16 lookups are held, and none is lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_ip | input | 32 | Destination address to look up |
| resp_valid | output | 1 | Result available |
| resp_ready | input | 1 | Consumer takes the result |
| resp_ip | output | 32 | Address the result belongs to |
| resp_result | output | 15 | Route found for resp_ip |
| mem_req_valid | output | 1 | Read request to the table memory |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Table word address |
| mem_rsp_valid | input | 1 | Read data returned (in issue order) |
| mem_rsp_data | input | 16 | Returned table word |

## Verification
A result is due after a chain of memory round trips, not after a fixed cycle count. The chain has one round trip per read the lookup needs, plus one cycle in each queue it passes through. The latency also changes with the memory latency and ready pattern the bench applies. The bench therefore does not predict an arrival cycle. It keeps a queue of expected results, computed by its own trie walk, and compares each result at the moment it is handed over, sampled mid-cycle after the inputs settle. Read counts and first addresses are checked only after an isolated lookup has fully drained. The stall test counts accepted lookups only after the pipeline has had ample cycles to fill.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Table word: [LPM_DW-1] leaf flag, [LPM_DW-2:0] payload (result or node base)
    localparam int unsigned LPM_DW    = 16;
    localparam int unsigned LPM_RES_W = LPM_DW - 1;
    localparam int unsigned LPM_IP_W  = 32;
    localparam int unsigned LPM_OCT_W = 8;
    localparam int unsigned LPM_NLEV  = 3;

    typedef struct packed {
        logic [LPM_IP_W-1:0]  ip;
        logic                 done;
        logic [LPM_RES_W-1:0] res;
    } lpm_ctx_t;

endpackage

// File: rtl/lpm_fifo.sv
module lpm_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4     // power of two
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW:0]   cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wr = st_q.wr + 1'b1;
        if (pop)  st_d.rd = st_q.rd + 1'b1;
        unique case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr] <= din;
    end

    assign full  = (st_q.cnt == (PW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign dout  = mem_q[st_q.rd];

    // R9: writers honour full, readers honour empty
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/lpm_port_arb.sv
module lpm_port_arb #(
    parameter int unsigned NS        = 3,
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 16,
    parameter int unsigned TAG_DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NS-1:0]          rd_req,
    input  logic [NS-1:0][AW-1:0]  rd_addr,
    output logic [NS-1:0]          rd_gnt,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [AW-1:0]          mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [DW-1:0]          mem_rsp_data,
    output logic [NS-1:0]          rsp_push,
    output logic [DW-1:0]          rsp_data
);
    localparam int unsigned TW = (NS > 1) ? $clog2(NS) : 1;

    logic [TW-1:0] sel;
    logic [TW-1:0] tag_head;
    logic          tag_full, tag_empty, fire;

    // deepest requesting stage wins: later loop iterations override
    always_comb begin
        sel = '0;
        for (int i = 0; i < NS; i++) begin
            if (rd_req[i]) sel = TW'(i);
        end
        mem_req_valid = (|rd_req) && !tag_full;
        mem_req_addr  = rd_addr[sel];
        fire          = mem_req_valid && mem_req_ready;
        rd_gnt        = '0;
        if (fire) rd_gnt[sel] = 1'b1;
        rsp_push      = '0;
        if (mem_rsp_valid) rsp_push[tag_head] = 1'b1;
        rsp_data      = mem_rsp_data;
    end

    lpm_fifo #(.W(TW), .DEPTH(TAG_DEPTH)) i_tag_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fire),
        .din   (sel),
        .full  (tag_full),
        .pop   (mem_rsp_valid),
        .dout  (tag_head),
        .empty (tag_empty)
    );

    // R8: one read issued per cycle
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_gnt));
    // R7: returned data always matches an outstanding read
    a_r7_rsp_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !tag_empty);

    for (genvar g = 0; g < NS - 1; g++) begin : g_prio
        // R8: no deeper stage was waiting when a shallower one was served
        a_r8_deepest_first: assert property (@(posedge clk) disable iff (!rst_n)
            rd_gnt[g] |-> (rd_req[NS-1:g+1] == '0));
    end

endmodule

// File: rtl/lpm_level.sv
module lpm_level
    import lpm_pkg::*;
#(
    parameter int unsigned LVL = 1,
    parameter int unsigned AW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  lpm_ctx_t          in_ctx,
    output logic              in_pop,
    input  logic              rsp_vld,
    input  logic [LPM_DW-1:0] rsp_data,
    output logic              rsp_pop,
    input  logic              out_full,
    output logic              out_push,
    output lpm_ctx_t          out_ctx,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_gnt
);
    localparam int unsigned OCT_LSB = LPM_IP_W - LPM_OCT_W * (LVL + 1);

    logic                 leaf;
    logic [LPM_RES_W-1:0] payload;
    logic [LPM_OCT_W-1:0] octet;

    always_comb begin
        leaf     = rsp_data[LPM_DW-1];
        payload  = rsp_data[LPM_DW-2:0];
        octet    = in_ctx.ip[OCT_LSB +: LPM_OCT_W];
        rd_addr  = AW'(payload) + AW'(octet);
        in_pop   = 1'b0;
        rsp_pop  = 1'b0;
        out_push = 1'b0;
        rd_req   = 1'b0;
        out_ctx  = in_ctx;
        if (in_vld && !out_full) begin
            if (in_ctx.done) begin
                in_pop   = 1'b1;
                out_push = 1'b1;
            end else if (rsp_vld) begin
                if (leaf) begin
                    in_pop      = 1'b1;
                    rsp_pop     = 1'b1;
                    out_push    = 1'b1;
                    out_ctx.done = 1'b1;
                    out_ctx.res  = payload;
                end else begin
                    rd_req = 1'b1;
                    if (rd_gnt) begin
                        in_pop   = 1'b1;
                        rsp_pop  = 1'b1;
                        out_push = 1'b1;
                    end
                end
            end
        end
    end

    // R4: a resolved lookup neither reads memory nor consumes read data here
    a_r4_skip_read: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_ctx.done) |-> (!rd_req && !rsp_pop));
    // R8: the arbiter grants only a stage that asked
    a_r8_gnt_requested: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gnt |-> rd_req);

endmodule

// File: rtl/lpm_finish.sv
module lpm_finish
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  lpm_ctx_t          in_ctx,
    output logic              in_pop,
    input  logic              rsp_vld,
    input  logic [LPM_DW-1:0] rsp_data,
    output logic              rsp_pop,
    input  logic              out_full,
    output logic              out_push,
    output lpm_ctx_t          out_ctx
);
    logic leaf_unused;

    // R5: the last level always yields a result, leaf flag or not
    always_comb begin
        leaf_unused = rsp_data[LPM_DW-1];
        in_pop      = 1'b0;
        rsp_pop     = 1'b0;
        out_push    = 1'b0;
        out_ctx     = in_ctx;
        if (in_vld && !out_full) begin
            if (in_ctx.done) begin
                in_pop   = 1'b1;
                out_push = 1'b1;
            end else if (rsp_vld) begin
                in_pop       = 1'b1;
                rsp_pop      = 1'b1;
                out_push     = 1'b1;
                out_ctx.done = 1'b1;
                out_ctx.res  = rsp_data[LPM_DW-2:0];
            end
        end
    end

    a_r4_last_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_ctx.done) |-> !rsp_pop);

endmodule

// File: rtl/lpm_linear_pipe.sv
module lpm_linear_pipe
    import lpm_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned TAG_DEPTH  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [LPM_IP_W-1:0]  req_ip,
    output logic                 resp_valid,
    input  logic                 resp_ready,
    output logic [LPM_IP_W-1:0]  resp_ip,
    output logic [LPM_RES_W-1:0] resp_result,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [AW-1:0]        mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [LPM_DW-1:0]    mem_rsp_data
);
    localparam int unsigned NLEV = LPM_NLEV;
    localparam int unsigned NQ   = NLEV + 1;   // lookup queues incl. output

    // lookup queues: queue j is written by stage j and read by stage j+1
    logic     c_push [NQ];
    logic     c_pop  [NQ];
    logic     c_full [NQ];
    logic     c_empty[NQ];
    lpm_ctx_t c_din  [NQ];
    lpm_ctx_t c_dout [NQ];

    // read-data queues: queue j holds words for stage j+1
    logic              r_pop       [NLEV];
    logic              r_empty     [NLEV];
    logic              r_full_unused[NLEV];
    logic [LPM_DW-1:0] r_dout      [NLEV];

    logic [NLEV-1:0]         arb_req;
    logic [NLEV-1:0][AW-1:0] arb_addr;
    logic [NLEV-1:0]         arb_gnt;
    logic [NLEV-1:0]         arb_rsp_push;
    logic [LPM_DW-1:0]       arb_rsp_data;

    // stage 0: accept a lookup only together with its first read
    assign arb_req[0]  = req_valid && !c_full[0];
    assign arb_addr[0] = AW'(req_ip[LPM_IP_W-1 -: LPM_OCT_W]);
    assign req_ready   = arb_gnt[0];
    assign c_push[0]   = arb_gnt[0];
    assign c_din[0]    = '{ip: req_ip, done: 1'b0, res: '0};

    for (genvar j = 0; j < NQ; j++) begin : g_cq
        lpm_fifo #(.W($bits(lpm_ctx_t)), .DEPTH(FIFO_DEPTH)) i_cq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (c_push[j]),
            .din   (c_din[j]),
            .full  (c_full[j]),
            .pop   (c_pop[j]),
            .dout  (c_dout[j]),
            .empty (c_empty[j])
        );
    end

    for (genvar j = 0; j < NLEV; j++) begin : g_rq
        lpm_fifo #(.W(LPM_DW), .DEPTH(FIFO_DEPTH)) i_rq (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (arb_rsp_push[j]),
            .din   (arb_rsp_data),
            .full  (r_full_unused[j]),
            .pop   (r_pop[j]),
            .dout  (r_dout[j]),
            .empty (r_empty[j])
        );
    end

    for (genvar k = 1; k <= NLEV; k++) begin : g_stage
        if (k < NLEV) begin : g_mid
            lpm_level #(.LVL(k), .AW(AW)) i_level (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (!c_empty[k-1]),
                .in_ctx   (c_dout[k-1]),
                .in_pop   (c_pop[k-1]),
                .rsp_vld  (!r_empty[k-1]),
                .rsp_data (r_dout[k-1]),
                .rsp_pop  (r_pop[k-1]),
                .out_full (c_full[k]),
                .out_push (c_push[k]),
                .out_ctx  (c_din[k]),
                .rd_req   (arb_req[k]),
                .rd_addr  (arb_addr[k]),
                .rd_gnt   (arb_gnt[k])
            );
        end else begin : g_last
            lpm_finish i_finish (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (!c_empty[k-1]),
                .in_ctx   (c_dout[k-1]),
                .in_pop   (c_pop[k-1]),
                .rsp_vld  (!r_empty[k-1]),
                .rsp_data (r_dout[k-1]),
                .rsp_pop  (r_pop[k-1]),
                .out_full (c_full[k]),
                .out_push (c_push[k]),
                .out_ctx  (c_din[k])
            );
        end
    end

    lpm_port_arb #(.NS(NLEV), .AW(AW), .DW(LPM_DW), .TAG_DEPTH(TAG_DEPTH)) i_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_req        (arb_req),
        .rd_addr       (arb_addr),
        .rd_gnt        (arb_gnt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_push      (arb_rsp_push),
        .rsp_data      (arb_rsp_data)
    );

    assign resp_valid    = !c_empty[NQ-1];
    assign c_pop[NQ-1]   = resp_valid && resp_ready;
    assign resp_ip       = c_dout[NQ-1].ip;
    assign resp_result   = c_dout[NQ-1].res;

    // R9: a stalled response holds still
    a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_ip) && $stable(resp_result)));
    // R8: acceptance coincides with the lookup's own first read
    a_r8_accept_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (mem_req_valid && mem_req_ready &&
                                      mem_req_addr == AW'(req_ip[LPM_IP_W-1 -: LPM_OCT_W])));
    // R6: results leave only with the done mark set
    a_r6_done_out: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> c_dout[NQ-1].done);

endmodule

// File: tb/test_lpm_linear_pipe.sv
module test_lpm_linear_pipe;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_ip;
    logic        resp_valid;
    logic        resp_ready;
    logic [31:0] resp_ip;
    logic [14:0] resp_result;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_data;

    always #10 clk = ~clk;   // 50 MHz

    lpm_linear_pipe i_lpm_linear_pipe (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ip(req_ip),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_ip(resp_ip), .resp_result(resp_result),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [15:0] tbl [int unsigned];

    // memory model controls
    int          lat_mode = 0;
    int          lat_fix  = 1;
    bit          rdy_rand = 0;
    bit          out_rand = 0;
    bit          out_hold = 0;
    logic [15:0] lfsr     = 16'hACE1;
    int          nreads   = 0;
    logic [15:0] first_addr = '0;
    logic [15:0] mq[$];
    int          mdue[$];

    // expected results
    logic [31:0] exp_ip[$];
    logic [14:0] exp_res[$];
    string       exp_tag[$];
    int          accepted = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] tword(input logic [15:0] a);
        return tbl.exists(int'(a)) ? tbl[int'(a)] : 16'hFFFF;
    endfunction

    // independent trie walk
    task automatic ref_walk(input logic [31:0] ip, output logic [14:0] res,
                            output int nr, output logic [15:0] a0);
        logic [15:0] a;
        logic [15:0] w;
        a  = {8'h00, ip[31:24]};
        a0 = a;
        w  = tword(a);
        nr = 1;
        if (!w[15]) begin
            a  = {1'b0, w[14:0]} + {8'h00, ip[23:16]};
            w  = tword(a);
            nr = 2;
            if (!w[15]) begin
                a  = {1'b0, w[14:0]} + {8'h00, ip[15:8]};
                w  = tword(a);
                nr = 3;
            end
        end
        res = w[14:0];
    endtask

    // memory model: ready and read data change at negedge, handshake seen 1 ns later
    initial begin
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = rdy_rand ? (lfsr[3] | lfsr[9]) : 1'b1;
            if (mq.size() > 0 && mdue[0] <= cyc) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mq.pop_front();
                void'(mdue.pop_front());
            end else begin
                mem_rsp_valid = 1'b0;
            end
            #1;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                int due;
                due = cyc + ((lat_mode != 0) ? (1 + int'(lfsr[10:8])) : lat_fix);
                if (mdue.size() > 0 && due < mdue[$]) due = mdue[$];
                if (nreads == 0) first_addr = mem_req_addr;
                nreads++;
                mq.push_back(tword(mem_req_addr));
                mdue.push_back(due);
            end
        end
    end

    // response monitor
    initial begin
        logic        prev_stall;
        logic [31:0] prev_ip;
        logic [14:0] prev_res;
        prev_stall = 1'b0;
        prev_ip    = '0;
        prev_res   = '0;
        resp_ready = 1'b0;
        forever begin
            @(negedge clk);
            resp_ready = out_hold ? 1'b0 : (out_rand ? lfsr[5] : 1'b1);
            #2;
            if (rst_n) begin
                if (prev_stall)
                    chk(resp_valid && resp_ip == prev_ip && resp_result == prev_res,
                        "R9", "stalled response changed", {resp_valid, resp_ip, 17'(resp_result)},
                        {1'b1, prev_ip, 17'(prev_res)});
                prev_stall = resp_valid && !resp_ready;
                prev_ip    = resp_ip;
                prev_res   = resp_result;
                if (resp_valid && resp_ready) begin
                    if (exp_ip.size() == 0) begin
                        chk(1'b0, "R6", "unexpected result", resp_ip, 0);
                    end else begin
                        logic [31:0] eip;
                        logic [14:0] eres;
                        string       etag;
                        eip  = exp_ip.pop_front();
                        eres = exp_res.pop_front();
                        etag = exp_tag.pop_front();
                        chk(resp_ip == eip, "R6", "result order (ip)", resp_ip, eip);
                        chk(resp_result == eres, etag, "result value", resp_result, eres);
                    end
                end
            end
        end
    end

    task automatic send(input logic [31:0] ip, input string tag);
        logic [14:0] r;
        int          nr;
        logic [15:0] a0;
        ref_walk(ip, r, nr, a0);
        @(negedge clk);
        req_valid = 1'b1;
        req_ip    = ip;
        #2;
        while (!req_ready) begin
            @(negedge clk);
            #2;
        end
        // R8: acceptance goes with the lookup's own first read
        chk(mem_req_addr == a0, "R8", "address at acceptance", mem_req_addr, a0);
        exp_ip.push_back(ip);
        exp_res.push_back(r);
        exp_tag.push_back(tag);
        accepted++;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_drain(input string tag);
        int t;
        t = 0;
        while ((exp_ip.size() != 0 || mq.size() != 0) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(exp_ip.size() == 0, tag, "all results delivered", exp_ip.size(), 0);
    endtask

    task automatic t_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_ip    = '0;
        repeat (4) @(negedge clk);
        #2;
        chk(!resp_valid, "R1", "resp_valid in reset", resp_valid, 0);
        chk(!mem_req_valid, "R1", "mem_req_valid in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk(!resp_valid, "R1", "resp_valid after reset", resp_valid, 0);
        chk(!mem_req_valid, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    endtask

    // isolated lookup: read count (R4) and first address (R2)
    task automatic t_single(input logic [31:0] ip, input string tag);
        logic [14:0] r;
        int          nr;
        logic [15:0] a0;
        ref_walk(ip, r, nr, a0);
        nreads = 0;
        send(ip, tag);
        wait_drain(tag);
        chk(nreads == nr, "R4", "reads per lookup", nreads, nr);
        chk(first_addr == a0, "R2", "first read address", first_addr, a0);
    endtask

    function automatic logic [31:0] pick(input int i);
        case (i % 7)
            0: return 32'h0A112233;
            1: return 32'h0B0608FF;
            2: return 32'h0B05AA00;
            3: return 32'h0B060712;
            4: return 32'h0C000000;
            5: return 32'h0B090001;
            default: return 32'h0B06AA00;
        endcase
    endfunction

    // back-to-back mixed lookups under a given memory behaviour
    task automatic t_burst(input int n, input int lm, input int lf,
                           input bit rr, input bit orand, input int seed);
        lat_mode = lm;
        lat_fix  = lf;
        rdy_rand = rr;
        out_rand = orand;
        for (int i = 0; i < n; i++) send(pick(i * 3 + seed), "R7");
        wait_drain("R7");
        rdy_rand = 0;
        out_rand = 0;
        lat_mode = 0;
        lat_fix  = 1;
    endtask

    // output blocked: queues fill, intake stops at 16 lookups
    task automatic t_stall();
        int base;
        base     = accepted;
        lat_fix  = 3;
        out_hold = 1;
        fork
            begin
                for (int i = 0; i < 20; i++) send(pick(i), "R9");
            end
            begin
                repeat (150) @(negedge clk);
                chk(accepted - base == 16, "R9", "lookups held while blocked",
                    accepted - base, 16);
                chk(resp_valid, "R9", "response waiting while blocked", resp_valid, 1);
                out_hold = 0;
            end
        join
        wait_drain("R9");
        lat_fix = 1;
    endtask

    initial begin
        // table: leaf flag bit 15, payload bits 14:0
        tbl[32'h000A] = 16'h8011;   // leaf at first level
        tbl[32'h000B] = 16'h0100;   // node
        tbl[32'h0105] = 16'h8022;   // leaf at second level
        tbl[32'h0106] = 16'h0200;   // node
        tbl[32'h0207] = 16'h8033;   // leaf at third level
        tbl[32'h0208] = 16'h0044;   // third word without leaf flag

        t_reset();
        t_single(32'h0A112233, "R2");
        t_single(32'h0C000000, "R2");
        t_single(32'h0B05AA00, "R3");
        t_single(32'h0B0607FF, "R3");
        t_single(32'h0B060812, "R5");
        t_single(32'h0B090000, "R4");
        t_single(32'h0B06AA00, "R4");
        t_burst(28, 0, 1, 0, 0, 0);
        t_burst(28, 0, 9, 0, 0, 1);
        t_burst(40, 1, 1, 1, 1, 2);
        t_stall();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=%0d expected=0", exp_ip.size());
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule